// File: doc/BRIEF.md
# Fractional-Divisor Oversampling Tick Generator

This block derives the sampling enable for one serial channel from a fast reference clock. The reference first passes through a prescaler that either passes every clock or keeps one clock in four. The prescaled clock then feeds a divisor made of a 16-bit integer part and a 4-bit fraction in steps of 1/16. The result is a one-cycle sample tick at 16, 8 or 4 times the serial bit rate. A bit strobe marks the tick that closes each bit time in the chosen oversampling mode.

Each tick period lasts either I or I+1 prescaled clocks, where I is the integer divisor. A 4-bit phase counter steps once per tick. A period is stretched by one prescaled clock when the bit-reversed phase is below the fraction F. Over any 16 consecutive ticks that start at phase 0, exactly F periods are stretched. Reversing the phase bits spreads those stretches evenly, so every group of 8 or 4 ticks aligned to the phase carries a near-equal share.

The divisor, fraction, prescaler and mode inputs come straight from the channel's register fields. They are copied into the active configuration only when a tick fires. A period that is already running therefore always completes at the length it started with.

Top module: `frac_baud_gen`

## Requirements
- R1: While reset is asserted, sample_tick and bit_strobe are low. Reset loads the active configuration with divisor 1, fraction 0, prescaler /1 and 16X mode. The first sample_tick therefore appears one clock after reset is released, and input values present at that time govern the periods from the second tick onward.
- R2: The period between consecutive ticks, in reference clocks, is P·(I+s). Here I = div_hi·256 + div_lo, s is 0 or 1, and P is the prescale ratio.
- R3: Tick n, counted from 0 after reset, closes the period whose phase is n mod 16. That period is stretched (s = 1) exactly when the bit-reversed 4-bit phase is below div_frac. Any 16 consecutive periods starting at phase 0 therefore sum to P·(16·I+F) reference clocks.
- R4: P is 1 when presc_div4 is 0 and 4 when presc_div4 is 1.
- R5: The mode inputs select the strobe spacing. With os_x8=0 and os_x4=0 the mode is 16X, and bit_strobe accompanies ticks with n mod 16 = 15. With only os_x8=1 the mode is 8X (n mod 8 = 7). With only os_x4=1 the mode is 4X (n mod 4 = 3). With both set the block behaves as 16X. bit_strobe is never high without sample_tick.
- R6: In 8X mode with an odd fraction, the bit time built from phases 0–7 is exactly P reference clocks longer than the one built from phases 8–15.
- R7: An integer divisor of 0 (both bytes zero) is treated as 1.
- R8: A change to any configuration input during a period leaves that period's length unchanged. The new values govern the period that starts at the next tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_lo | input | 8 | Integer divisor, low byte |
| div_hi | input | 8 | Integer divisor, high byte |
| div_frac | input | 4 | Fractional divisor in sixteenths |
| presc_div4 | input | 1 | 1 selects the divide-by-4 prescaler |
| os_x8 | input | 1 | Selects 8X oversampling |
| os_x4 | input | 1 | Selects 4X oversampling |
| sample_tick | output | 1 | One-cycle sampling enable |
| bit_strobe | output | 1 | Marks the tick that ends a bit time |

## Verification
Both outputs are registered. Each one rises one reference clock after the edge on which the period counter expires, so the first tick is visible at the first falling edge after reset release. The bench samples at falling edges and measures every gap in whole cycles from one observed tick to the next. A configuration applied under reset first governs period 1, so in /4 mode the first period can be cut short by the free-running prescaler; the sweeps judge only ticks 16 to 31, whose periods are exact. A register write made mid-period is checked against the gap that closes that period, which must keep the old length, and against the following gap, which must take the new one.

// File: rtl/frac_baud_pkg.sv
package frac_baud_pkg;

    parameter int BYTE_W = 8;
    parameter int INT_W  = 2 * BYTE_W;
    parameter int FRAC_W = 4;

    typedef enum logic [1:0] {
        OS_X16 = 2'd0,
        OS_X8  = 2'd1,
        OS_X4  = 2'd2
    } os_mode_e;

    typedef struct packed {
        logic [INT_W-1:0]  idiv;
        logic [FRAC_W-1:0] frac;
        logic              div4;
        os_mode_e          mode;
    } bg_cfg_t;

    localparam bg_cfg_t CFG_RESET = '{
        idiv: INT_W'(1),
        frac: '0,
        div4: 1'b0,
        mode: OS_X16
    };

    // Reserved combination (both selects set) falls back to 16X.
    function automatic os_mode_e decode_mode(input logic sel8, input logic sel4);
        case ({sel8, sel4})
            2'b10:   return OS_X8;
            2'b01:   return OS_X4;
            default: return OS_X16;
        endcase
    endfunction

endpackage

// File: rtl/fbg_prescaler.sv
module fbg_prescaler #(
    parameter int RATIO = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic div_on,
    output logic en
);
    localparam int W = $clog2(RATIO);
    localparam logic [W-1:0] LAST = W'(RATIO - 1);

    typedef struct packed {
        logic [W-1:0] cnt;
    } pre_st_t;

    pre_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt == LAST) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + W'(1);
        end
        en = !div_on || (st_q.cnt == LAST);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // While dividing, an enable is never followed directly by another.
    AST_PRE_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        (div_on && en) |=> (!div_on || !en)); // R4

endmodule

// File: rtl/fbg_cfg_shadow.sv
module fbg_cfg_shadow
    import frac_baud_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    load,
    input  bg_cfg_t cfg_in,
    output bg_cfg_t cfg_out
);
    typedef struct packed {
        bg_cfg_t cfg;
    } sh_st_t;

    sh_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.cfg = cfg_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cfg <= CFG_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_out = st_q.cfg;

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(cfg_out)); // R8
    AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        2'(cfg_out.mode) != 2'b11); // R5

endmodule

// File: rtl/fbg_divider.sv
module fbg_divider
    import frac_baud_pkg::*;
#(
    parameter int CNT_W = INT_W,
    parameter int PH_W  = FRAC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  os_mode_e         act_mode,
    input  logic [CNT_W-1:0] act_idiv,
    input  logic [CNT_W-1:0] nxt_idiv,
    input  logic [PH_W-1:0]  nxt_frac,
    output logic             fire,
    output logic             tick,
    output logic             strobe
);
    localparam logic [PH_W-1:0] MASK16 = '1;
    localparam logic [PH_W-1:0] MASK8  = MASK16 >> 1;
    localparam logic [PH_W-1:0] MASK4  = MASK16 >> 2;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [PH_W-1:0]  phase;
        logic             tick;
        logic             strobe;
    } div_st_t;

    div_st_t st_d, st_q;

    logic [PH_W-1:0] phase_nx;
    logic [PH_W-1:0] rev_nx;
    logic [PH_W-1:0] bit_mask;
    logic            stretch;

    assign phase_nx = st_q.phase + PH_W'(1);

    // Bit-reversed phase spreads the stretched periods evenly.
    for (genvar i = 0; i < PH_W; i++) begin : g_rev
        assign rev_nx[i] = phase_nx[PH_W-1-i];
    end

    always_comb begin
        case (act_mode)
            OS_X8:   bit_mask = MASK8;
            OS_X4:   bit_mask = MASK4;
            default: bit_mask = MASK16;
        endcase
        stretch = (rev_nx < nxt_frac);
        fire    = en && (st_q.cnt == '0);

        st_d        = st_q;
        st_d.tick   = 1'b0;
        st_d.strobe = 1'b0;
        if (fire) begin
            st_d.cnt    = nxt_idiv - CNT_W'(1) + CNT_W'(stretch);
            st_d.phase  = phase_nx;
            st_d.tick   = 1'b1;
            st_d.strobe = ((st_q.phase & bit_mask) == bit_mask);
        end else if (en) begin
            st_d.cnt = st_q.cnt - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick   = st_q.tick;
    assign strobe = st_q.strobe;

    AST_STROBE_IN_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |-> tick); // R5
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= act_idiv); // R2
    AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> (st_q.phase == $past(st_q.phase) + PH_W'(1))); // R3

endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen
    import frac_baud_pkg::*;
#(
    parameter int PRE_RATIO = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] div_lo,
    input  logic [BYTE_W-1:0] div_hi,
    input  logic [FRAC_W-1:0] div_frac,
    input  logic              presc_div4,
    input  logic              os_x8,
    input  logic              os_x4,
    output logic              sample_tick,
    output logic              bit_strobe
);
    bg_cfg_t          cfg_nxt;
    bg_cfg_t          cfg_act;
    logic [INT_W-1:0] raw_idiv;
    logic             pre_en;
    logic             fire;

    always_comb begin
        raw_idiv     = {div_hi, div_lo};
        cfg_nxt.idiv = (raw_idiv == '0) ? INT_W'(1) : raw_idiv;
        cfg_nxt.frac = div_frac;
        cfg_nxt.div4 = presc_div4;
        cfg_nxt.mode = decode_mode(os_x8, os_x4);
    end

    fbg_prescaler #(
        .RATIO (PRE_RATIO)
    ) i_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .div_on (cfg_act.div4),
        .en     (pre_en)
    );

    fbg_cfg_shadow i_shadow (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (fire),
        .cfg_in  (cfg_nxt),
        .cfg_out (cfg_act)
    );

    fbg_divider #(
        .CNT_W (INT_W),
        .PH_W  (FRAC_W)
    ) i_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (pre_en),
        .act_mode (cfg_act.mode),
        .act_idiv (cfg_act.idiv),
        .nxt_idiv (cfg_nxt.idiv),
        .nxt_frac (cfg_nxt.frac),
        .fire     (fire),
        .tick     (sample_tick),
        .strobe   (bit_strobe)
    );

    AST_IDIV_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_act.idiv != '0); // R7
    AST_LOAD_ON_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> sample_tick); // R8

endmodule

// File: tb/test_frac_baud_gen.sv
module test_frac_baud_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] div_lo = 8'd1;
    logic [7:0] div_hi = 8'd0;
    logic [3:0] div_frac = 4'd0;
    logic       presc_div4 = 1'b0;
    logic       os_x8 = 1'b0;
    logic       os_x4 = 1'b0;
    logic       sample_tick;
    logic       bit_strobe;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    frac_baud_gen i_frac_baud_gen (
        .clk(clk), .rst_n(rst_n), .div_lo(div_lo), .div_hi(div_hi),
        .div_frac(div_frac), .presc_div4(presc_div4), .os_x8(os_x8),
        .os_x4(os_x4), .sample_tick(sample_tick), .bit_strobe(bit_strobe)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_len(input int idiv, input int fr, input int p, input int ph);
        int rv;
        rv = ((ph & 1) << 3) | ((ph & 2) << 1) | ((ph & 4) >> 1) | ((ph & 8) >> 3);
        return p * (idiv + ((rv < fr) ? 1 : 0));
    endfunction

    task automatic wait_tick(output int gap);
        gap = 0;
        do begin
            @(negedge clk);
            gap++;
        end while (!sample_tick && gap < 20000);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(sample_tick == 1'b0, "R1 tick in reset", int'(sample_tick), 0);
        check(bit_strobe == 1'b0, "R1 strobe in reset", int'(bit_strobe), 0);
        rst_n = 1'b1;
    endtask

    task automatic apply(input int idiv, input int fr, input int p4, input int md);
        div_lo     = 8'(idiv);
        div_hi     = 8'(idiv >> 8);
        div_frac   = 4'(fr);
        presc_div4 = p4[0];
        os_x8      = (md == 1 || md == 3);
        os_x4      = (md == 2 || md == 3);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
        $finish;
    end

    initial begin
        int gap;
        // R1: defaults govern period 0, inputs from period 1
        apply(9, 0, 0, 0);
        do_reset();
        wait_tick(gap);
        check(gap == 1, "R1 first tick", gap, 1);
        wait_tick(gap);
        check(gap == 9, "R1 period one uses inputs", gap, 9);

        // Sweep: R2 R3 R4 R5 R6
        for (int p4 = 0; p4 < 2; p4++) begin
            for (int ii = 0; ii < 2; ii++) begin
                for (int fr = 0; fr < 16; fr++) begin
                    int idiv;
                    int p;
                    int md;
                    int mask;
                    int sum;
                    int h1;
                    int h2;
                    idiv = (ii == 0) ? 1 : 3;
                    p    = (p4 == 1) ? 4 : 1;
                    md   = fr % 4;
                    mask = (md == 1) ? 7 : ((md == 2) ? 3 : 15);
                    apply(idiv, fr, p4, md);
                    do_reset();
                    for (int k = 0; k < 16; k++) wait_tick(gap);
                    sum = 0; h1 = 0; h2 = 0;
                    for (int k = 16; k < 32; k++) begin
                        wait_tick(gap);
                        sum += gap;
                        if (k < 24) h1 += gap; else h2 += gap;
                        check(gap == exp_len(idiv, fr, p, k % 16), "R2 R3 period", gap,
                              exp_len(idiv, fr, p, k % 16));
                        check(int'(bit_strobe) == (((k & mask) == mask) ? 1 : 0),
                              "R5 strobe", int'(bit_strobe), ((k & mask) == mask) ? 1 : 0);
                    end
                    check(sum == p * (16 * idiv + fr), "R3 R4 sixteen-tick sum", sum,
                          p * (16 * idiv + fr));
                    if (md == 1 && (fr % 2) == 1) begin
                        check(h1 - h2 == p, "R6 odd-fraction 8X jitter", h1 - h2, p);
                    end
                end
            end
        end

        // R7: zero integer divisor behaves as 1
        apply(0, 0, 0, 0);
        do_reset();
        wait_tick(gap);
        for (int k = 1; k < 6; k++) begin
            wait_tick(gap);
            check(gap == 1, "R7 zero divisor", gap, 1);
        end

        // R2: high byte participates in the divisor
        apply(258, 5, 0, 0);
        do_reset();
        wait_tick(gap);
        begin
            int sum;
            sum = 0;
            for (int k = 1; k < 17; k++) begin
                wait_tick(gap);
                sum += gap;
            end
            check(sum == 16 * 258 + 5, "R2 high byte sum", sum, 16 * 258 + 5);
        end

        // R8: mid-period change takes effect only after next tick
        apply(4, 0, 0, 0);
        do_reset();
        for (int k = 0; k < 5; k++) wait_tick(gap);
        repeat (2) @(negedge clk);
        apply(7, 0, 0, 0);
        wait_tick(gap);
        check(gap + 2 == 4, "R8 running period kept", gap + 2, 4);
        wait_tick(gap);
        check(gap == 7, "R8 new divisor next period", gap, 7);
        wait_tick(gap);
        check(gap == 7, "R8 new divisor holds", gap, 7);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule